// File: doc/BRIEF.md
# RAM Chip-Enable Gate

This block sits in the active-low chip-enable path between a processor and a static RAM that must keep its contents through a power failure. While the supply supervisor reports a healthy supply, the processor's chip-enable passes straight through to the memory with no register in the path. When the supervisor flags reset, the path closes and the memory sees a deselected (high) chip-enable, whatever the processor does. This keeps corrupted accesses away from the memory while the supply collapses.

The path does not always close at once. If the processor is driving the chip-enable low at the moment reset is flagged, a write may be under way. The gate then waits, for a bounded time, until the processor ends that access. It closes on the first clock edge at which the chip-enable is seen high, or when a timeout measured in clock cycles runs out, whichever comes first. It opens again only when the supervisor lets go of reset. A status output tells the rest of the system whether the path is currently open.

Top module: `ram_ce_gate`

## Requirements
- R1: While the gate is open and the supervisor reset flag is low, `ce_n_o` equals `ce_n_i` in the same cycle, with no clock delay, for both levels.
- R2: While the gate is closed, `ce_n_o` is 1 for any value of `ce_n_i`.
- R3: If `ce_n_i` is 1 at the clock edge where `sup_rst_i` is first sampled high, the gate is closed after that edge.
- R4: If `ce_n_i` is 0 at the clock edge where `sup_rst_i` is first sampled high, the gate stays open and `ce_n_o` keeps following `ce_n_i`. The gate closes at the first later edge where `ce_n_i` is sampled high.
- R5: If `ce_n_i` stays 0 during the deferral, the gate closes at the TIMEOUT_CYC-th edge after the edge that started the deferral. `ce_n_o` is then 1 even though `ce_n_i` is still 0.
- R6: A closed gate stays closed while `sup_rst_i` is 1. At the first edge that samples `sup_rst_i` low, from any state, the gate opens.
- R7: `gate_on_o` is 1 while the path is open or deferring, and 0 while it is closed.
- R8: After the synchronous system reset `rst_i`, the gate is closed, `gate_on_o` is 0 and `ce_n_o` is 1.
- R9: The timeout count restarts from zero whenever `sup_rst_i` is released, so a later deferral gets the full TIMEOUT_CYC window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous system reset, active high |
| sup_rst_i | input | 1 | Supervisor reset flag, active high (supply not good) |
| ce_n_i | input | 1 | Chip-enable from the processor, active low |
| ce_n_o | output | 1 | Chip-enable to the memory, active low |
| gate_on_o | output | 1 | High while the chip-enable path is open or deferring its closure |

## Verification
A state register stuck in the deferring state would keep `gate_on_o` high for longer than TIMEOUT_CYC+1 cycles of reset. It would also let a new low pulse through to `ce_n_o`. Both are visible within one timeout window. A gate that closes too early shows at once: a chip-enable held low reads back high on the very next cycle after reset is raised. A gate that fails to reopen leaves `ce_n_o` stuck high one cycle after release. An off-by-one in the timeout counter moves the falling edge of `gate_on_o` by exactly one cycle. The tests probe that edge on both sides.

// File: rtl/ram_ce_gate_pkg.sv
package ram_ce_gate_pkg;

    typedef enum logic [1:0] {
        GATE_OPEN  = 2'b00,
        GATE_DRAIN = 2'b01,
        GATE_SHUT  = 2'b10
    } gate_state_e;

    typedef struct packed {
        gate_state_e state;
    } gate_fsm_regs_t;

    function automatic logic gate_is_on(gate_state_e s);
        return (s != GATE_SHUT);
    endfunction

endpackage

// File: rtl/ram_ce_gate_timer.sv
module ram_ce_gate_timer #(
    parameter int TIMEOUT_CYC = 500
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clear_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int CNT_W = (TIMEOUT_CYC < 2) ? 1 : $clog2(TIMEOUT_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } timer_regs_t;

    timer_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clear_i) begin
            r_d.cnt = '0;
        end else if (run_i && (r_q.cnt != LAST)) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign expired_o = (r_q.cnt == LAST);
endmodule

// File: rtl/ram_ce_gate_fsm.sv
module ram_ce_gate_fsm
    import ram_ce_gate_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        sup_rst_i,
    input  logic        ce_n_i,
    input  logic        expired_i,
    output gate_state_e state_o,
    output logic        tmr_clear_o,
    output logic        tmr_run_o
);
    gate_fsm_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!sup_rst_i) begin
            r_d.state = GATE_OPEN;
        end else begin
            unique case (r_q.state)
                GATE_OPEN:  r_d.state = ce_n_i ? GATE_SHUT : GATE_DRAIN;
                GATE_DRAIN: r_d.state = (ce_n_i || expired_i) ? GATE_SHUT : GATE_DRAIN;
                GATE_SHUT:  r_d.state = GATE_SHUT;
                default:    r_d.state = GATE_SHUT;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r_q.state <= GATE_SHUT;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o     = r_q.state;
    assign tmr_run_o   = (r_q.state == GATE_DRAIN);
    assign tmr_clear_o = !sup_rst_i || (r_q.state != GATE_DRAIN);
endmodule

// File: rtl/ram_ce_gate_mux.sv
module ram_ce_gate_mux
    import ram_ce_gate_pkg::*;
(
    input  gate_state_e state_i,
    input  logic        ce_n_i,
    output logic        ce_n_o,
    output logic        gate_on_o
);
    logic on_w;

    always_comb begin
        on_w      = gate_is_on(state_i);
        gate_on_o = on_w;
        ce_n_o    = on_w ? ce_n_i : 1'b1;
    end
endmodule

// File: rtl/ram_ce_gate.sv
module ram_ce_gate
    import ram_ce_gate_pkg::*;
#(
    parameter int TIMEOUT_CYC = 500
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic sup_rst_i,
    input  logic ce_n_i,
    output logic ce_n_o,
    output logic gate_on_o
);
    gate_state_e state_w;
    logic        tmr_clear_w;
    logic        tmr_run_w;
    logic        expired_w;

    ram_ce_gate_fsm fsm_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .sup_rst_i   (sup_rst_i),
        .ce_n_i      (ce_n_i),
        .expired_i   (expired_w),
        .state_o     (state_w),
        .tmr_clear_o (tmr_clear_w),
        .tmr_run_o   (tmr_run_w)
    );

    ram_ce_gate_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) timer_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .clear_i   (tmr_clear_w),
        .run_i     (tmr_run_w),
        .expired_o (expired_w)
    );

    ram_ce_gate_mux mux_i (
        .state_i   (state_w),
        .ce_n_i    (ce_n_i),
        .ce_n_o    (ce_n_o),
        .gate_on_o (gate_on_o)
    );
endmodule

// File: rtl/ram_ce_gate_chk.sv
module ram_ce_gate_chk #(
    parameter int TIMEOUT_CYC = 500
) (
    input logic clk_i,
    input logic rst_i,
    input logic sup_rst_i,
    input logic ce_n_i,
    input logic ce_n_o,
    input logic gate_on_o
);
    localparam int WIN_W = $clog2(TIMEOUT_CYC + 3);
    logic [WIN_W-1:0] win_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || !(sup_rst_i && gate_on_o)) begin
            win_q <= '0;
        end else if (win_q != {WIN_W{1'b1}}) begin
            win_q <= win_q + 1'b1;
        end
    end

    AST_SHUT_DESELECTS: assert property (@(posedge clk_i) disable iff (rst_i)
        !gate_on_o |-> ce_n_o); // R2
    AST_PASS_THROUGH: assert property (@(posedge clk_i) disable iff (rst_i)
        (gate_on_o && !sup_rst_i) |-> (ce_n_o == ce_n_i)); // R1
    AST_HIGH_AT_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
        (gate_on_o && sup_rst_i && ce_n_i) |=> !gate_on_o); // R3
    AST_REOPEN: assert property (@(posedge clk_i) disable iff (rst_i)
        !sup_rst_i |=> gate_on_o); // R6
    AST_STAY_SHUT: assert property (@(posedge clk_i) disable iff (rst_i)
        (!gate_on_o && sup_rst_i) |=> !gate_on_o); // R6
    AST_DRAIN_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
        (sup_rst_i && gate_on_o) |-> (int'(win_q) <= TIMEOUT_CYC)); // R5
endmodule

bind ram_ce_gate ram_ce_gate_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) chk_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .sup_rst_i (sup_rst_i),
    .ce_n_i    (ce_n_i),
    .ce_n_o    (ce_n_o),
    .gate_on_o (gate_on_o)
);

// File: tb/ram_ce_gate_tb_top.sv
`timescale 1ns/1ps
module ram_ce_gate_tb_top;
    localparam int LIM = 500;

    logic clk = 1'b0;
    logic rst_i, sup_rst_i, ce_n_i;
    logic ce_n_o, gate_on_o;
    int   n_chk = 0;
    int   n_bad = 0;

    always #10 clk = ~clk;

    ram_ce_gate #(.TIMEOUT_CYC(LIM)) dut_i (
        .clk_i     (clk),
        .rst_i     (rst_i),
        .sup_rst_i (sup_rst_i),
        .ce_n_i    (ce_n_i),
        .ce_n_o    (ce_n_o),
        .gate_on_o (gate_on_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic t_reset_state();
        rst_i = 1'b1; sup_rst_i = 1'b0; ce_n_i = 1'b0;
        step(); step();
        check("R8 out", ce_n_o, 1'b1);
        check("R8 status", gate_on_o, 1'b0);
        rst_i = 1'b0;
        #1;
    endtask

    task automatic t_pass_through();
        sup_rst_i = 1'b0; ce_n_i = 1'b1;
        step();
        check("R7 open status", gate_on_o, 1'b1);
        ce_n_i = 1'b0; #1;
        check("R1 low", ce_n_o, 1'b0);
        ce_n_i = 1'b1; #1;
        check("R1 high", ce_n_o, 1'b1);
        step();
        ce_n_i = 1'b0; #1;
        check("R1 low again", ce_n_o, 1'b0);
        ce_n_i = 1'b1; #1;
    endtask

    task automatic t_close_when_idle();
        ce_n_i = 1'b1; sup_rst_i = 1'b1;
        step();
        check("R3 closed", gate_on_o, 1'b0);
        ce_n_i = 1'b0; #1;
        check("R2 blocked low", ce_n_o, 1'b1);
        for (int i = 0; i < 5; i++) step();
        check("R6 stays shut", gate_on_o, 1'b0);
        check("R2 still blocked", ce_n_o, 1'b1);
        sup_rst_i = 1'b0;
        step();
        check("R6 reopened", gate_on_o, 1'b1);
        check("R6 passes low", ce_n_o, 1'b0);
        ce_n_i = 1'b1; #1;
    endtask

    task automatic t_defer_until_rise();
        ce_n_i = 1'b0; sup_rst_i = 1'b1;
        step();
        check("R4 still open", gate_on_o, 1'b1);
        check("R4 low passes", ce_n_o, 1'b0);
        step(); step(); step();
        check("R7 drain status", gate_on_o, 1'b1);
        ce_n_i = 1'b1;
        step();
        check("R4 closed on rise", gate_on_o, 1'b0);
        ce_n_i = 1'b0; #1;
        check("R4 no new pulse", ce_n_o, 1'b1);
        sup_rst_i = 1'b0; ce_n_i = 1'b1;
        step();
        check("R6 reopen after drain", gate_on_o, 1'b1);
    endtask

    task automatic t_timeout();
        ce_n_i = 1'b0; sup_rst_i = 1'b1;
        step();
        for (int i = 0; i < LIM - 1; i++) step();
        check("R5 open before expiry", gate_on_o, 1'b1);
        step();
        check("R5 closed at expiry", gate_on_o, 1'b0);
        check("R5 output high", ce_n_o, 1'b1);
        sup_rst_i = 1'b0; ce_n_i = 1'b1;
        step();
    endtask

    task automatic t_restart();
        ce_n_i = 1'b0; sup_rst_i = 1'b1;
        step();
        for (int i = 0; i < 20; i++) step();
        sup_rst_i = 1'b0;
        step();
        check("R9 reopened", gate_on_o, 1'b1);
        sup_rst_i = 1'b1;
        step();
        for (int i = 0; i < LIM - 1; i++) step();
        check("R9 full window", gate_on_o, 1'b1);
        step();
        check("R9 closed at end", gate_on_o, 1'b0);
        sup_rst_i = 1'b0; ce_n_i = 1'b1;
        step();
    endtask

    initial begin
        t_reset_state();
        t_pass_through();
        t_close_when_idle();
        t_defer_until_rise();
        t_timeout();
        t_restart();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(20.0 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule